// File: doc/BRIEF.md
# Byte-Lane Dual-Port Pipelined RAM

This block is a word-addressed storage array with two fully symmetric access ports, called left and right. Each port has its own clock and reset, an address, a read/write select, two chip selects of opposite polarity, and a pair of active-low lane enables. Each 18-bit word is split into two 9-bit lanes. Either port may read or write any word. On a write, only the enabled lanes are updated. On a read, only the enabled lanes are returned.

Reads are pipelined. The port registers its inputs on one rising edge and loads the output register on the next edge. Each lane of the output carries a flag that stands in for a driven pad; a lane whose flag is low also reads as zero. An active-low output enable gates these flags without waiting for a clock. After reset, or after any cycle in which the port is not selected, the port must be selected for a number of consecutive cycles before a read is allowed to drive its outputs again.

Both ports may address the same word in the same cycle. If both ports write the same lane of the same word on the same edge, the left port's data is kept. The depth is a parameter and must be a power of two. The stored contents are cleared to zero by reset.

Top module: `dpr_byte_ram`

## Requirements
- R1: A port is selected only when its `ce0_n` is 0 and its `ce1` is 1. In any other combination, a write leaves memory unchanged and a read leaves both lane flags at 0.
- R2: The lower lane is word bits 8:0, controlled by `lane_n[0]`. The upper lane is bits 17:9, controlled by `lane_n[1]`. A selected write (`rd_wr_n`=0) updates exactly the lanes whose `lane_n` bit is 0.
- R3: A selected read sampled on rising edge E puts its data and flags on the outputs just after edge E+1. They hold until edge E+2.
- R4: A read drives only the lanes whose `lane_n` bit is 0: the flag is 1 and the data is the stored lane. Any other lane has flag 0 and data 0. A read with both bits at 1 leaves both flags at 0.
- R5: While `oe_n` is 1, both lane flags and all data bits of that port are 0. This takes effect without any clock edge and is undone as soon as `oe_n` returns to 0.
- R6: After reset, or after any sampled cycle in which the port is deselected, a read in the first selected cycle leaves both flags at 0. A read in the next consecutive selected cycle is returned normally (RECOVER = 2).
- R7: With both ports on one clock, suppose a write on one port is sampled on edge E. A read of the same word on the other port sampled on edge E returns the old contents. A read sampled on edge E+1 returns the new contents.
- R8: When both ports write the same lane of the same word on the same edge, the left port's data is stored. A lane written by only one of the ports takes that port's data.
- R9: After reset, every word reads as zero, and both ports show flags 0 and data 0.
- R10: A selected write cycle produces no output: the output cycle that follows it has both flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock, rising edge |
| l_rst_n | input | 1 | Left port reset, active low, asynchronous |
| l_ce0_n | input | 1 | Left chip select, active low |
| l_ce1 | input | 1 | Left chip select, active high |
| l_rd_wr_n | input | 1 | Left access type: 1 read, 0 write |
| l_lane_n | input | 2 | Left lane enables, active low; bit 0 lower lane, bit 1 upper lane |
| l_oe_n | input | 1 | Left output enable, active low, asynchronous |
| l_addr | input | AW | Left word address, AW = log2(DEPTH) |
| l_wdata | input | 18 | Left write data |
| l_rdata | output | 18 | Left read data, disabled lanes zero |
| l_rd_lane_vld | output | 2 | Left per-lane output-driven flags |
| r_clk | input | 1 | Right port clock, rising edge |
| r_rst_n | input | 1 | Right port reset, active low, asynchronous |
| r_ce0_n | input | 1 | Right chip select, active low |
| r_ce1 | input | 1 | Right chip select, active high |
| r_rd_wr_n | input | 1 | Right access type: 1 read, 0 write |
| r_lane_n | input | 2 | Right lane enables, active low; bit 0 lower lane, bit 1 upper lane |
| r_oe_n | input | 1 | Right output enable, active low, asynchronous |
| r_addr | input | AW | Right word address |
| r_wdata | input | 18 | Right write data |
| r_rdata | output | 18 | Right read data, disabled lanes zero |
| r_rd_lane_vld | output | 2 | Right per-lane output-driven flags |

## Verification
The lane logic is exercised with every lane-enable pattern, on one word whose two lanes were written by separate partial writes, so that a swapped or merged lane mask gives a wrong value. Latency is checked with back-to-back reads of two different words, which separates a correct one-cycle pipeline from a zero- or two-cycle one. The chip-select combinations, a single deselected cycle followed by two reads, and an output-enable pulse between edges separate the select decode, the reactivation count and the asynchronous gating. Same-edge writes on both ports, and reads issued on the same edge as a write and one edge after it, pin down the collision priority and when new data becomes visible across ports.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;

  // Spread one bit per lane over the full lane width.
  function automatic word_t lane_expand(input lane_mask_t m);
    word_t w;
    for (int i = 0; i < LANES; i++) w[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
    return w;
  endfunction
endpackage

// File: rtl/dpr_recover.sv
// Counts consecutive selected cycles; a read may drive outputs only once
// the port has been selected for RECOVER cycles in a row.
module dpr_recover #(
  parameter int RECOVER = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic warm
);
  localparam int RW = (RECOVER > 1) ? $clog2(RECOVER) : 1;
  localparam logic [RW-1:0] RUN_MAX = RW'(RECOVER - 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (!sel)            run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + RW'(1);
  end

  assign warm = sel && (run_q == RUN_MAX);
endmodule

// File: rtl/dpr_port_ctl.sv
// One access port: input register stage, then registered read output.
module dpr_port_ctl
  import dpr_pkg::*;
#(
  parameter int AW      = 8,
  parameter int RECOVER = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          rd_wr_n,
  input  lane_mask_t    lane_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  word_t         wdata,
  input  word_t         rword,
  output lane_mask_t    cm_we,
  output logic [AW-1:0] cm_addr,
  output word_t         cm_wdata,
  output word_t         rdata,
  output lane_mask_t    rd_lane_vld
);
  logic       sel;
  logic       warm;
  lane_mask_t lanes;
  lane_mask_t cm_rd;
  lane_mask_t out_lane_q;
  word_t      out_word_q;

  assign sel   = !ce0_n && ce1;
  assign lanes = ~lane_n;

  dpr_recover #(.RECOVER(RECOVER)) u_rec (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (sel),
    .warm (warm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_we      <= '0;
      cm_rd      <= '0;
      cm_addr    <= '0;
      cm_wdata   <= '0;
      out_lane_q <= '0;
      out_word_q <= '0;
    end else begin
      // Stage 1: sampled access. Writes are allowed while cold.
      cm_we      <= (sel && !rd_wr_n) ? lanes : '0;
      cm_rd      <= (warm && rd_wr_n) ? lanes : '0;
      cm_addr    <= addr;
      cm_wdata   <= wdata;
      // Stage 2: registered read result.
      out_lane_q <= cm_rd;
      out_word_q <= rword & lane_expand(cm_rd);
    end
  end

  assign rd_lane_vld = out_lane_q & {LANES{!oe_n}};
  assign rdata       = out_word_q & lane_expand(rd_lane_vld);
endmodule

// File: rtl/dpr_array.sv
// Two-writer storage built from one bank per port: the word is the XOR of
// both banks, so each bank has exactly one writing clock.
module dpr_array
  import dpr_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          l_clk,
  input  logic          l_rst_n,
  input  lane_mask_t    l_we,
  input  logic [AW-1:0] l_addr,
  input  word_t         l_wdata,
  output word_t         l_rword,
  input  logic          r_clk,
  input  logic          r_rst_n,
  input  lane_mask_t    r_we,
  input  logic [AW-1:0] r_addr,
  input  word_t         r_wdata,
  output word_t         r_rword
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank_l [DEPTH];
    logic [LANE_W-1:0] bank_r [DEPTH];
    logic              r_yield;

    // Same lane, same word, left writing: right's write is dropped.
    assign r_yield = l_we[g] && (l_addr == r_addr);

    always_ff @(posedge l_clk or negedge l_rst_n) begin
      if (!l_rst_n) begin
        for (int i = 0; i < DEPTH; i++) bank_l[i] <= '0;
      end else if (l_we[g]) begin
        bank_l[l_addr] <= l_wdata[g*LANE_W +: LANE_W] ^ bank_r[l_addr];
      end
    end

    always_ff @(posedge r_clk or negedge r_rst_n) begin
      if (!r_rst_n) begin
        for (int i = 0; i < DEPTH; i++) bank_r[i] <= '0;
      end else if (r_we[g] && !r_yield) begin
        bank_r[r_addr] <= r_wdata[g*LANE_W +: LANE_W] ^ bank_l[r_addr];
      end
    end

    assign l_rword[g*LANE_W +: LANE_W] = bank_l[l_addr] ^ bank_r[l_addr];
    assign r_rword[g*LANE_W +: LANE_W] = bank_l[r_addr] ^ bank_r[r_addr];
  end
endmodule

// File: rtl/dpr_byte_ram.sv
module dpr_byte_ram
  import dpr_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int RECOVER = 2,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          l_clk,
  input  logic          l_rst_n,
  input  logic          l_ce0_n,
  input  logic          l_ce1,
  input  logic          l_rd_wr_n,
  input  logic [1:0]    l_lane_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [17:0]   l_wdata,
  output logic [17:0]   l_rdata,
  output logic [1:0]    l_rd_lane_vld,
  input  logic          r_clk,
  input  logic          r_rst_n,
  input  logic          r_ce0_n,
  input  logic          r_ce1,
  input  logic          r_rd_wr_n,
  input  logic [1:0]    r_lane_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [17:0]   r_wdata,
  output logic [17:0]   r_rdata,
  output logic [1:0]    r_rd_lane_vld
);
  lane_mask_t    l_cm_we, r_cm_we;
  logic [AW-1:0] l_cm_addr, r_cm_addr;
  word_t         l_cm_wdata, r_cm_wdata;
  word_t         l_rword, r_rword;

  dpr_port_ctl #(.AW(AW), .RECOVER(RECOVER)) u_left (
    .clk        (l_clk),
    .rst_n      (l_rst_n),
    .ce0_n      (l_ce0_n),
    .ce1        (l_ce1),
    .rd_wr_n    (l_rd_wr_n),
    .lane_n     (l_lane_n),
    .oe_n       (l_oe_n),
    .addr       (l_addr),
    .wdata      (l_wdata),
    .rword      (l_rword),
    .cm_we      (l_cm_we),
    .cm_addr    (l_cm_addr),
    .cm_wdata   (l_cm_wdata),
    .rdata      (l_rdata),
    .rd_lane_vld(l_rd_lane_vld)
  );

  dpr_port_ctl #(.AW(AW), .RECOVER(RECOVER)) u_right (
    .clk        (r_clk),
    .rst_n      (r_rst_n),
    .ce0_n      (r_ce0_n),
    .ce1        (r_ce1),
    .rd_wr_n    (r_rd_wr_n),
    .lane_n     (r_lane_n),
    .oe_n       (r_oe_n),
    .addr       (r_addr),
    .wdata      (r_wdata),
    .rword      (r_rword),
    .cm_we      (r_cm_we),
    .cm_addr    (r_cm_addr),
    .cm_wdata   (r_cm_wdata),
    .rdata      (r_rdata),
    .rd_lane_vld(r_rd_lane_vld)
  );

  dpr_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .l_clk  (l_clk),
    .l_rst_n(l_rst_n),
    .l_we   (l_cm_we),
    .l_addr (l_cm_addr),
    .l_wdata(l_cm_wdata),
    .l_rword(l_rword),
    .r_clk  (r_clk),
    .r_rst_n(r_rst_n),
    .r_we   (r_cm_we),
    .r_addr (r_cm_addr),
    .r_wdata(r_cm_wdata),
    .r_rword(r_rword)
  );
endmodule

// File: rtl/dpr_port_chk.sv
// Per-port protocol checker, bound once to each side of the top module.
module dpr_port_chk
  import dpr_pkg::*;
#(
  parameter int RECOVER = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce0_n,
  input logic             ce1,
  input logic             rd_wr_n,
  input logic [LANES-1:0] lane_n,
  input logic             oe_n,
  input logic [WORD_W-1:0] rdata,
  input logic [LANES-1:0] vld
);
  localparam int CW = $clog2(RECOVER + 1);

  logic          sel;
  logic          warm;
  logic [CW-1:0] run;

  assign sel = !ce0_n && ce1;

  // Consecutive selected samples seen before the current edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run <= '0;
    else if (!sel)                run <= '0;
    else if (run < CW'(RECOVER))  run <= run + CW'(1);
  end

  assign warm = sel && (run >= CW'(RECOVER - 1));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R3: a driven lane traces back to a read of that lane two edges earlier
    p_read_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vld[g] |-> $past(sel && rd_wr_n && !lane_n[g], 2));
    // R4: an undriven lane carries zero data
    p_dead_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !vld[g] |-> (rdata[g*LANE_W +: LANE_W] == '0));
  end

  p_oe_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (vld == '0));

  p_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld != '0) |-> $past(warm, 2));

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sel, 2) |-> (vld == '0));

  p_write_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel && !rd_wr_n, 2) |-> (vld == '0));
endmodule

bind dpr_byte_ram dpr_port_chk #(.RECOVER(RECOVER)) u_chk_left (
  .clk    (l_clk),
  .rst_n  (l_rst_n),
  .ce0_n  (l_ce0_n),
  .ce1    (l_ce1),
  .rd_wr_n(l_rd_wr_n),
  .lane_n (l_lane_n),
  .oe_n   (l_oe_n),
  .rdata  (l_rdata),
  .vld    (l_rd_lane_vld)
);

bind dpr_byte_ram dpr_port_chk #(.RECOVER(RECOVER)) u_chk_right (
  .clk    (r_clk),
  .rst_n  (r_rst_n),
  .ce0_n  (r_ce0_n),
  .ce1    (r_ce1),
  .rd_wr_n(r_rd_wr_n),
  .lane_n (r_lane_n),
  .oe_n   (r_oe_n),
  .rdata  (r_rdata),
  .vld    (r_rd_lane_vld)
);

// File: tb/tb_dpr_byte_ram.sv
module tb_dpr_byte_ram;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst_n;
  logic          l_ce0_n, l_ce1, l_rd_wr_n, l_oe_n;
  logic [1:0]    l_lane_n;
  logic [AW-1:0] l_addr;
  logic [17:0]   l_wdata, l_rdata;
  logic [1:0]    l_vld;
  logic          r_ce0_n, r_ce1, r_rd_wr_n, r_oe_n;
  logic [1:0]    r_lane_n;
  logic [AW-1:0] r_addr;
  logic [17:0]   r_wdata, r_rdata;
  logic [1:0]    r_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [17:0] ref_mem [DEPTH];

  dpr_byte_ram #(.DEPTH(DEPTH), .RECOVER(2)) dut (
    .l_clk(clk), .l_rst_n(rst_n), .l_ce0_n(l_ce0_n), .l_ce1(l_ce1),
    .l_rd_wr_n(l_rd_wr_n), .l_lane_n(l_lane_n), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rd_lane_vld(l_vld),
    .r_clk(clk), .r_rst_n(rst_n), .r_ce0_n(r_ce0_n), .r_ce1(r_ce1),
    .r_rd_wr_n(r_rd_wr_n), .r_lane_n(r_lane_n), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rd_lane_vld(r_vld)
  );

  task automatic set_op(input bit side, input logic c0n, input logic c1, input logic rd,
                        input logic [1:0] ln, input logic [AW-1:0] a, input logic [17:0] d);
    if (!side) begin
      l_ce0_n = c0n; l_ce1 = c1; l_rd_wr_n = rd; l_lane_n = ln; l_addr = a; l_wdata = d;
    end else begin
      r_ce0_n = c0n; r_ce1 = c1; r_rd_wr_n = rd; r_lane_n = ln; r_addr = a; r_wdata = d;
    end
  endtask

  // Selected, read, no lanes: keeps the port warm without output.
  task automatic idle(input bit side);
    set_op(side, 1'b0, 1'b1, 1'b1, 2'b11, '0, '0);
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic logic [19:0] port_out(input bit side);
    return side ? {r_vld, r_rdata} : {l_vld, l_rdata};
  endfunction

  function automatic logic [19:0] expect_rd(input logic [AW-1:0] a, input logic [1:0] ln);
    logic [17:0] m;
    m = {{9{~ln[1]}}, {9{~ln[0]}}};
    return {~ln, ref_mem[a] & m};
  endfunction

  task automatic ref_wr(input logic [AW-1:0] a, input logic [1:0] ln, input logic [17:0] d);
    if (!ln[0]) ref_mem[a][8:0]  = d[8:0];
    if (!ln[1]) ref_mem[a][17:9] = d[17:9];
  endtask

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input bit side, input logic [AW-1:0] a, input logic [1:0] ln,
                          input logic [17:0] d);
    set_op(side, 1'b0, 1'b1, 1'b0, ln, a, d);
    tick;
    idle(side);
    ref_wr(a, ln, d);
  endtask

  task automatic do_read(input bit side, input logic [AW-1:0] a, input logic [1:0] ln,
                         input string req);
    set_op(side, 1'b0, 1'b1, 1'b1, ln, a, '0);
    tick;
    idle(side);
    tick;
    chk(req, port_out(side), expect_rd(a, ln));
  endtask

  // R9: cleared state straight after reset
  task automatic t_reset_state;
    chk("R9 left outputs", port_out(0), 20'h0);
    chk("R9 right outputs", port_out(1), 20'h0);
    tick; tick;
    do_read(0, 8'd5, 2'b00, "R9 left word");
    do_read(1, 8'(DEPTH - 1), 2'b00, "R9 right word");
  endtask

  // R2, R4: partial writes and every read lane pattern
  task automatic t_lanes;
    do_write(0, 8'd10, 2'b00, 18'h15555);
    do_write(0, 8'd10, 2'b10, 18'h3F0F0);
    do_read(0, 8'd10, 2'b00, "R2 lower-only write");
    do_read(0, 8'd10, 2'b10, "R4 lower lane read");
    do_read(0, 8'd10, 2'b01, "R4 upper lane read");
    do_read(0, 8'd10, 2'b11, "R4 no lane read");
    do_write(1, 8'd11, 2'b00, 18'h0F00F);
    do_write(1, 8'd11, 2'b01, 18'h2AB55);
    do_read(1, 8'd11, 2'b00, "R2 upper-only write");
  endtask

  // R3, R10: back-to-back reads and a following write
  task automatic t_latency;
    do_write(0, 8'd50, 2'b00, 18'h0ABCD);
    do_write(0, 8'd51, 2'b00, 18'h31337);
    set_op(0, 1'b0, 1'b1, 1'b1, 2'b00, 8'd50, '0);
    tick;
    chk("R3 not yet visible", port_out(0), 20'h0);
    set_op(0, 1'b0, 1'b1, 1'b1, 2'b00, 8'd51, '0);
    tick;
    chk("R3 first read", port_out(0), expect_rd(8'd50, 2'b00));
    set_op(0, 1'b0, 1'b1, 1'b0, 2'b00, 8'd52, 18'h12345);
    tick;
    chk("R3 second read", port_out(0), expect_rd(8'd51, 2'b00));
    idle(0);
    ref_wr(8'd52, 2'b00, 18'h12345);
    tick;
    chk("R10 write cycle output", port_out(0), 20'h0);
    do_read(0, 8'd52, 2'b00, "R10 write landed");
  endtask

  // R1: every non-selecting chip-select combination
  task automatic t_deselect;
    for (int k = 0; k < 3; k++) begin
      logic c0n, c1;
      c0n = (k != 1);
      c1  = (k == 1) ? 1'b0 : (k == 0);
      set_op(0, c0n, c1, 1'b0, 2'b00, 8'd60, 18'h3FFFF);
      tick;
      set_op(0, c0n, c1, 1'b1, 2'b00, 8'd10, '0);
      tick;
      idle(0);
      tick;
      chk("R1 deselected read", port_out(0), 20'h0);
      tick;
    end
    do_read(0, 8'd60, 2'b00, "R1 deselected write dropped");
  endtask

  // R6: one deselected cycle, then two reads
  task automatic t_recover;
    set_op(0, 1'b1, 1'b1, 1'b1, 2'b00, 8'd10, '0);
    tick;
    set_op(0, 1'b0, 1'b1, 1'b1, 2'b00, 8'd10, '0);
    tick;
    set_op(0, 1'b0, 1'b1, 1'b1, 2'b00, 8'd10, '0);
    tick;
    chk("R6 first selected read", port_out(0), 20'h0);
    idle(0);
    tick;
    chk("R6 second selected read", port_out(0), expect_rd(8'd10, 2'b00));
  endtask

  // R5: output enable pulse between edges
  task automatic t_oe;
    set_op(0, 1'b0, 1'b1, 1'b1, 2'b00, 8'd10, '0);
    tick;
    idle(0);
    tick;
    #1 l_oe_n = 1'b1;
    #1 chk("R5 disabled", port_out(0), 20'h0);
    l_oe_n = 1'b0;
    #1 chk("R5 re-enabled", port_out(0), expect_rd(8'd10, 2'b00));
    @(negedge clk);
  endtask

  // R7: cross-port visibility, both directions
  task automatic t_cross;
    logic [19:0] old;
    old = expect_rd(8'd40, 2'b00);
    set_op(0, 1'b0, 1'b1, 1'b0, 2'b00, 8'd40, 18'h1C3A5);
    set_op(1, 1'b0, 1'b1, 1'b1, 2'b00, 8'd40, '0);
    tick;
    idle(0);
    ref_wr(8'd40, 2'b00, 18'h1C3A5);
    tick;
    chk("R7 same-edge read old", port_out(1), old);
    idle(1);
    tick;
    chk("R7 next-edge read new", port_out(1), expect_rd(8'd40, 2'b00));

    old = expect_rd(8'd41, 2'b00);
    set_op(1, 1'b0, 1'b1, 1'b0, 2'b00, 8'd41, 18'h2E6D1);
    set_op(0, 1'b0, 1'b1, 1'b1, 2'b00, 8'd41, '0);
    tick;
    idle(1);
    ref_wr(8'd41, 2'b00, 18'h2E6D1);
    tick;
    chk("R7 reverse same-edge old", port_out(0), old);
    idle(0);
    tick;
    chk("R7 reverse next-edge new", port_out(0), expect_rd(8'd41, 2'b00));
  endtask

  // R8: same-edge writes to one word
  task automatic t_collide;
    set_op(0, 1'b0, 1'b1, 1'b0, 2'b10, 8'd30, 18'h001A5);
    set_op(1, 1'b0, 1'b1, 1'b0, 2'b00, 8'd30, 18'h3C0F3);
    tick;
    idle(0); idle(1);
    ref_wr(8'd30, 2'b00, 18'h3C0F3);
    ref_wr(8'd30, 2'b10, 18'h001A5);
    do_read(0, 8'd30, 2'b00, "R8 split lanes left");
    do_read(1, 8'd30, 2'b00, "R8 split lanes right");
    set_op(0, 1'b0, 1'b1, 1'b0, 2'b00, 8'd31, 18'h0AAAA);
    set_op(1, 1'b0, 1'b1, 1'b0, 2'b00, 8'd31, 18'h35555);
    tick;
    idle(0); idle(1);
    ref_wr(8'd31, 2'b00, 18'h35555);
    ref_wr(8'd31, 2'b00, 18'h0AAAA);
    do_read(1, 8'd31, 2'b00, "R8 left wins both lanes");
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    rst_n  = 1'b0;
    l_oe_n = 1'b0;
    r_oe_n = 1'b0;
    idle(0);
    idle(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state;
    t_lanes;
    t_latency;
    t_deselect;
    t_recover;
    t_oe;
    t_cross;
    t_collide;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule